// File: doc/BRIEF.md
# Word-Addressed Register Bank Slave

This block is a bus slave holding a small bank of general-purpose data registers, reached through a single-clock, pipelined AHB-style slave port. A master presents an address and control set in one cycle; the slave latches it and carries out the data transfer in the next cycle. Meanwhile the master may already present the following address phase, so accesses can stream back to back with no wait states.

Full-word accesses are served with an OKAY response and no wait states. Any narrower or wider access size is refused with the standard two-cycle ERROR response, and it leaves the bank untouched. Sequential beats are accepted, but every beat is handled as an independent single access at the address it carries. There is no burst address generation.

An internal controller with idle, read and write states, plus two error states, orders the work. The register index comes from the word-address bits just above the byte-lane bits. All address bits above and below the index are ignored.

Top module: `reg_bank_slave`

## Requirements
- R1: While reset is low and after it is released, every register reads as zero, the ready output is high and the response is OKAY (00).
- R2: An address phase is taken only when select, ready-in and a transfer type of NONSEQ (10) or SEQ (11) are present in the same cycle. IDLE (00), BUSY (01), a deselected slave and a low ready-in change no register, and they give ready high, OKAY and zero read data in the next cycle.
- R3: A word write (size code 010, write high) to the register chosen by address bits [4:2] stores the write data presented in the next cycle. That data cycle shows ready high and OKAY.
- R4: A word read (size 010, write low) returns the selected register on the read data output in the cycle after the address phase, with ready high and OKAY.
- R5: When a write address phase is followed at once by a read of the same register, the read returns the newly written value with no wait state.
- R6: A taken address phase with any size other than 010 gets ERROR (01) with ready low in the next cycle, then ERROR with ready high in the cycle after. No register changes.
- R7: A SEQ (11) transfer is served at the address it carries, exactly like a NONSEQ transfer, with no address increment.
- R8: The read data output is zero in every cycle that is not the data cycle of a word read.
- R9: Address bits above bit 4 and below bit 2 do not affect which register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave select from the address decoder |
| addr_i | input | ADDR_W | Byte address of the address phase |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| size_i | input | 3 | Access size code; 2^code bytes |
| write_i | input | 1 | 1 write, 0 read |
| wdata_i | input | DATA_W | Write data, valid in the data cycle |
| ready_in_i | input | 1 | Bus-wide ready: previous transfer finishing |
| rdata_o | output | DATA_W | Read data |
| ready_out_o | output | 1 | Slave ready; low inserts a wait cycle |
| resp_o | output | 2 | Response: 00 OKAY, 01 ERROR |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data and eight registers. With these values every register index and the full-word size code 010 are reachable, as are byte and halfword codes that must draw an error. A scoreboard queues the expected outputs of each data cycle. The stimulus covers streamed write-then-read pairs on the same register, sequential beats that jump between addresses, aliased high address bits, and ignored IDLE, BUSY, deselected and not-ready cycles. After each ignored or refused access, the registers are read back to show they are unchanged.

// File: rtl/reg_bank_pkg.sv
package reg_bank_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01
  } resp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_ERR_WAIT,
    ST_ERR_LAST
  } state_e;

  // upper bit of the transfer code marks a real access (nonseq or seq)
  function automatic logic trans_active(input logic [1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/bank_phase_latch.sv
module bank_phase_latch #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       size_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       size_o
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [2:0]       size_q, size_d;

  always_comb begin
    idx_d  = idx_q;
    size_d = size_q;
    if (cap_en_i) begin
      idx_d  = idx_i;
      size_d = size_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      size_q <= '0;
    end else begin
      idx_q  <= idx_d;
      size_q <= size_d;
    end
  end

  assign idx_o  = idx_q;
  assign size_o = size_q;

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import reg_bank_pkg::*;
#(
  parameter logic [2:0] WORD_SIZE = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       write_i,
  input  logic [2:0] size_i,
  output state_e     state_o,
  output logic       cap_en_o,
  output logic       we_o,
  output logic       rd_en_o,
  output logic       ready_o,
  output logic [1:0] resp_o
);

  state_e state_q, state_d;
  logic   in_err_wait;

  assign in_err_wait = (state_q == ST_ERR_WAIT);

  // next-state decision
  always_comb begin
    state_d = ST_IDLE;
    if (in_err_wait) begin
      state_d = ST_ERR_LAST;
    end else if (accept_i) begin
      if (size_i != WORD_SIZE) begin
        state_d = ST_ERR_WAIT;
      end else if (write_i) begin
        state_d = ST_WRITE;
      end else begin
        state_d = ST_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // no new address phase is latched while the first error cycle holds the bus
  assign cap_en_o = accept_i && !in_err_wait;
  assign we_o     = (state_q == ST_WRITE);
  assign rd_en_o  = (state_q == ST_READ);
  assign ready_o  = !in_err_wait;

  always_comb begin
    resp_o = RSP_OKAY;
    if (in_err_wait || (state_q == ST_ERR_LAST)) begin
      resp_o = RSP_ERROR;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/bank_storage.sv
module bank_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  // one write enable per entry
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_decode
    assign hit[g] = we_i && (idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hit[i]) begin
          regs_q[i] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      rdata_o = regs_q[idx_i];
    end
  end

  // a write touches exactly one entry, never one during a read cycle
  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r3_single_entry: assert ($countones(hit) == (we_i ? 1 : 0))
        else $error("write decode hit %0d entries", $countones(hit));
    end
  end

endmodule

// File: rtl/reg_bank_slave.sv
module reg_bank_slave
  import reg_bank_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic [2:0]        size_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_in_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_out_o,
  output logic [1:0]        resp_o
);

  localparam int         BYTES     = DATA_W / 8;
  localparam int         LSB       = $clog2(BYTES);
  localparam int         IDX_W     = $clog2(NUM_REGS);
  localparam logic [2:0] WORD_SIZE = 3'(LSB);

  logic             accept;
  logic             cap_en;
  logic             we;
  logic             rd_en;
  logic [IDX_W-1:0] cur_idx;
  logic [2:0]       cur_size;
  state_e           state;
  logic             addr_unused;

  assign accept      = sel_i && ready_in_i && trans_active(trans_i);
  assign addr_unused = ^{addr_i[ADDR_W-1:LSB+IDX_W], addr_i[LSB-1:0]};

  bank_phase_latch #(
    .IDX_W (IDX_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (cap_en),
    .idx_i    (addr_i[LSB +: IDX_W]),
    .size_i   (size_i),
    .idx_o    (cur_idx),
    .size_o   (cur_size)
  );

  bank_ctrl #(
    .WORD_SIZE (WORD_SIZE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .write_i  (write_i),
    .size_i   (size_i),
    .state_o  (state),
    .cap_en_o (cap_en),
    .we_o     (we),
    .rd_en_o  (rd_en),
    .ready_o  (ready_out_o),
    .resp_o   (resp_o)
  );

  bank_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we),
    .idx_i   (cur_idx),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en),
    .rdata_o (rdata_o)
  );

  // R6: a wait cycle is always an error cycle
  a_r6_wait_is_error: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out_o |-> resp_o == RSP_ERROR);

  // R6: the wait cycle is followed by a ready error cycle
  a_r6_error_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out_o |=> (ready_out_o && resp_o == RSP_ERROR));

  // R6: a taken non-word phase stalls the next cycle
  a_r6_odd_size_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && size_i != WORD_SIZE && state != ST_ERR_WAIT) |=> !ready_out_o);

  // R6: storage is only written for a latched word access
  a_r6_word_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> cur_size == WORD_SIZE);

  // R2: nothing taken means a quiet, ready, OKAY next cycle
  a_r2_quiet_when_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && state != ST_ERR_WAIT) |=>
      (ready_out_o && resp_o == RSP_OKAY && rdata_o == '0));

  // R4: read data cycles are zero-wait OKAY
  a_r4_read_okay: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (ready_out_o && resp_o == RSP_OKAY));

endmodule

// File: tb/tb_reg_bank_slave.sv
module tb_reg_bank_slave;

  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NS = 2'b10, T_SQ = 2'b11;
  localparam logic [2:0] SZ_B = 3'b000, SZ_H = 3'b001, SZ_W = 3'b010;
  localparam logic [1:0] OKAY = 2'b00, ERR = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic [31:0] addr;
  logic [1:0]  trans;
  logic [2:0]  size;
  logic        wr;
  logic [31:0] wdata;
  logic        rdy_gate;
  logic        rdy_in;
  logic [31:0] rdata;
  logic        ready_out;
  logic [1:0]  resp;

  always #5 clk = ~clk;

  assign rdy_in = ready_out && rdy_gate;

  reg_bank_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .addr_i      (addr),
    .trans_i     (trans),
    .size_i      (size),
    .write_i     (wr),
    .wdata_i     (wdata),
    .ready_in_i  (rdy_in),
    .rdata_o     (rdata),
    .ready_out_o (ready_out),
    .resp_o      (resp)
  );

  typedef struct {
    logic        rdy;
    logic [1:0]  rsp;
    logic [31:0] dat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model [8];
  logic        pend_wr = 1'b0;
  logic [2:0]  pend_idx = '0;
  logic        pend_err = 1'b0;
  logic [31:0] stash = '0;

  // monitor: one expectation per cycle, sampled 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ready_out !== e.rdy || resp !== e.rsp || rdata !== e.dat) begin
        errors++;
        $display("FAIL %s: ready/resp/rdata = %0b/%0b/%h expected %0b/%0b/%h",
                 e.tag, ready_out, resp, rdata, e.rdy, e.rsp, e.dat);
      end
    end
  end

  // driver: present one address phase (plus data for the previous one)
  task automatic beat(input logic s, input logic [1:0] t, input logic w,
                      input logic [2:0] z, input logic [31:0] a,
                      input logic [31:0] d, input string tag);
    exp_t e;
    logic acc;
    sel = s; trans = t; wr = w; size = z; addr = a; wdata = stash;
    if (pend_wr) begin
      model[pend_idx] = stash;
      pend_wr = 1'b0;
    end
    acc = s && rdy_gate && t[1] && !pend_err;
    e.rdy = 1'b1; e.rsp = OKAY; e.dat = '0; e.tag = tag;
    if (pend_err) begin
      e.rsp = ERR;
      pend_err = 1'b0;
    end else if (acc && z != SZ_W) begin
      e.rdy = 1'b0; e.rsp = ERR;
      pend_err = 1'b1;
    end else if (acc && !w) begin
      e.dat = model[a[4:2]];
    end else if (acc) begin
      pend_wr = 1'b1;
      pend_idx = a[4:2];
    end
    stash = d;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    beat(1'b0, T_IDLE, 1'b0, SZ_W, 32'h0, 32'h0, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    rst_n = 1'b0; sel = 1'b0; addr = '0; trans = T_IDLE; size = SZ_W;
    wr = 1'b0; wdata = '0; rdy_gate = 1'b1;
    #23;
    checks++;
    if (ready_out !== 1'b1 || resp !== OKAY || rdata !== '0) begin
      errors++;
      $display("FAIL R1: in reset ready/resp/rdata = %0b/%0b/%h expected 1/0/0",
               ready_out, resp, rdata);
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all registers zero after reset
    for (int i = 0; i < 8; i++) beat(1'b1, T_NS, 1'b0, SZ_W, 32'(i * 4), 32'h0, "R1");
    idle("R8");

    // R3 writes then R4 reads of every register
    for (int i = 0; i < 8; i++)
      beat(1'b1, T_NS, 1'b1, SZ_W, 32'(i * 4), 32'hA500_0000 + 32'(i * 32'h0101), "R3");
    for (int i = 0; i < 8; i++) beat(1'b1, T_NS, 1'b0, SZ_W, 32'(i * 4), 32'h0, "R4");
    idle("R8");

    // R5: write immediately followed by read of the same register
    beat(1'b1, T_NS, 1'b1, SZ_W, 32'h14, 32'h1234_5678, "R5");
    beat(1'b1, T_NS, 1'b0, SZ_W, 32'h14, 32'h0, "R5");
    beat(1'b1, T_NS, 1'b1, SZ_W, 32'h00, 32'hCAFE_F00D, "R5");
    beat(1'b1, T_NS, 1'b0, SZ_W, 32'h00, 32'h0, "R5");
    idle("R8");

    // R2: ignored phases (idle, busy, deselected, ready-in low)
    beat(1'b1, T_IDLE, 1'b1, SZ_W, 32'h08, 32'hDEAD_0001, "R2");
    beat(1'b1, T_BUSY, 1'b1, SZ_W, 32'h08, 32'hDEAD_0002, "R2");
    beat(1'b0, T_NS,   1'b1, SZ_W, 32'h08, 32'hDEAD_0003, "R2");
    rdy_gate = 1'b0;
    beat(1'b1, T_NS,   1'b1, SZ_W, 32'h08, 32'hDEAD_0004, "R2");
    rdy_gate = 1'b1;
    beat(1'b1, T_NS,   1'b0, SZ_W, 32'h08, 32'h0, "R2");
    idle("R8");

    // R6: byte and halfword accesses error and change nothing
    beat(1'b1, T_NS, 1'b1, SZ_B, 32'h04, 32'hBAD0_0001, "R6");
    idle("R6");
    beat(1'b1, T_NS, 1'b1, SZ_H, 32'h04, 32'hBAD0_0002, "R6");
    idle("R6");
    beat(1'b1, T_NS, 1'b0, SZ_B, 32'h04, 32'h0, "R6");
    idle("R6");
    beat(1'b1, T_NS, 1'b0, SZ_W, 32'h04, 32'h0, "R6");
    idle("R8");

    // R7: seq beats use their own addresses, no increment
    beat(1'b1, T_NS, 1'b1, SZ_W, 32'h18, 32'h7777_0018, "R7");
    beat(1'b1, T_SQ, 1'b1, SZ_W, 32'h08, 32'h7777_0008, "R7");
    beat(1'b1, T_SQ, 1'b0, SZ_W, 32'h18, 32'h0, "R7");
    beat(1'b1, T_SQ, 1'b0, SZ_W, 32'h1C, 32'h0, "R7");
    beat(1'b1, T_SQ, 1'b0, SZ_W, 32'h08, 32'h0, "R7");
    idle("R8");

    // R9: aliasing of upper and lower address bits
    beat(1'b1, T_NS, 1'b1, SZ_W, 32'hFFFF_FF0C, 32'h9999_000C, "R9");
    beat(1'b1, T_NS, 1'b0, SZ_W, 32'h0000_000F, 32'h0, "R9");
    beat(1'b1, T_NS, 1'b0, SZ_W, 32'h0000_0010, 32'h0, "R9");
    idle("R8");
    idle("R8");

    wait (sb.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule